// File: doc/BRIEF.md
# Entropy Command Sequencer

The sequencer decides which command words reach a deterministic random bit generator and when. Three sources feed it. On the rising of the enable input a boot sequence fires an instantiate command and then a generate command with no software involvement, unless a boot-disable input holds it back. Software can push command words one by one through a write port. In automatic mode two small stores, one holding a reseed command and one holding a generate command, are replayed over and over. A generate replay happens only while some consumer is asking for bits, and a reseed replay is forced once a programmed number of generates has gone out since the last reseed.

Each command is a header word followed by 0 or 12 words of additional data. The header carries the command code in bits [3:0] (1 instantiate, 2 reseed, 3 generate) and the additional-data word count in bits [7:4]. Words leave on a valid/ready handshake, and after the last word of a command the sequencer waits for an acknowledge pulse from the generator before it starts the next command. A done pulse and a sticky done interrupt report completed software commands. Sticky error bits drive a fatal interrupt.

Top module: `ent_cmd_seq`

## Requirements
- R1: When enable_i rises with boot_dis_i low, the block sends header 32'h0000_0001, waits for gen_ack_i, then sends header 32'h0000_0003, with no software action.
- R2: After the last word of any command has been taken, no word of the next command is offered until gen_ack_i is seen high while the output is empty.
- R3: With boot_dis_i high when enable_i rises, no boot command is sent.
- R4: In software mode (auto_mode_i low), a header with length 0 or 12 and the data words that follow are forwarded in order. After the acknowledge, sw_done_o pulses and intr_done_o is set until done_clr_i.
- R5: A software header whose length field (bits [7:4]) is neither 0 nor 12 is discarded: nothing is sent, and err_code_o bit 0 is set.
- R6: In automatic mode a generate command is replayed from the generate store only while ep_req_i is non-zero. Replay does not consume the stores, so the same words are sent each time.
- R7: In automatic mode, once the count of generate commands since the last reseed reaches max_reqs_i, the reseed store is replayed and the count returns to zero.
- R8: A pulse on fifo_clr_i empties both stores, so automatic mode then sends nothing.
- R9: With enable_i low the output valid drops, the sequencer goes idle and the generate count returns to zero.
- R10: A write to a full store sets err_code_o bit 1. err_test_i sets the bits it names. Error bits are sticky until reset, and intr_fatal_o is their OR.
- R11: While gen_valid_o is high and gen_ready_i is low, gen_valid_o stays high and gen_data_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Sequencer enable; its rising edge starts boot |
| boot_dis_i | input | 1 | Suppresses the boot sequence |
| auto_mode_i | input | 1 | 1 selects automatic replay, 0 selects software commands |
| fifo_clr_i | input | 1 | Empties both command stores |
| max_reqs_i | input | 16 | Generates allowed between reseeds in automatic mode |
| sw_wvalid_i | input | 1 | Software command word valid |
| sw_wdata_i | input | 32 | Software command word |
| sw_rdy_o | output | 1 | Software word can be accepted this cycle |
| sw_done_o | output | 1 | Pulse when a software command is acknowledged |
| rs_wvalid_i | input | 1 | Write strobe for the reseed store |
| rs_wdata_i | input | 32 | Reseed store word |
| gn_wvalid_i | input | 1 | Write strobe for the generate store |
| gn_wdata_i | input | 32 | Generate store word |
| ep_req_i | input | 4 | Pending requests, one bit per consumer |
| gen_valid_o | output | 1 | Command word valid to the generator |
| gen_data_o | output | 32 | Command word to the generator |
| gen_ready_i | input | 1 | Generator takes the word |
| gen_ack_i | input | 1 | Generator has completed the command |
| done_clr_i | input | 1 | Clears intr_done_o |
| err_test_i | input | 2 | Forces error bits |
| intr_done_o | output | 1 | Sticky software-command-done interrupt |
| intr_fatal_o | output | 1 | Fatal error interrupt |
| err_code_o | output | 2 | Sticky error bits: bit 0 bad length, bit 1 store overflow |

## Verification
The hardest case to reach is the forced reseed at an exact point in the generate count, and the proof that disabling clears that count. The stimulus first stops the consumer requests right after a single generate, which leaves the count at one. It then toggles enable and lets replay resume. With a cleared count the stream must be two generates before the 13-word reseed; with a stale count the reseed comes early, and the scoreboard sees a mismatch. Backpressure is applied by toggling ready during the 12-word software reseed, and the acknowledge is held low after the boot instantiate to show the wait.

// File: rtl/ent_cmd_pkg.sv
package ent_cmd_pkg;
  localparam int WORD_W = 32;
  localparam int ADATA_LEN = 12;

  typedef enum logic [3:0] {
    CMD_NONE   = 4'd0,
    CMD_INST   = 4'd1,
    CMD_RESEED = 4'd2,
    CMD_GEN    = 4'd3
  } cmd_code_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_BOOT_INS, ST_BOOT_INS_ACK, ST_BOOT_GEN, ST_BOOT_GEN_ACK,
    ST_RUN, ST_SW_DATA, ST_SW_ACK, ST_AUTO_SEND, ST_AUTO_ACK
  } seq_state_e;

  function automatic logic [3:0] hdr_len(input logic [WORD_W-1:0] w);
    return w[7:4];
  endfunction

  function automatic logic len_ok(input logic [WORD_W-1:0] w);
    return (w[7:4] == 4'd0) || (w[7:4] == 4'(ADATA_LEN));
  endfunction

  function automatic logic [WORD_W-1:0] mk_hdr(input cmd_code_e c);
    return {{(WORD_W-4){1'b0}}, c};
  endfunction
endpackage

// File: rtl/ent_cmd_store.sv
module ent_cmd_store #(
  parameter int DEPTH = 13,
  parameter int W     = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [CNT_W-1:0] rd_idx_i,
  output logic [W-1:0]     rdata_o,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] count_q;
  logic [W-1:0]     mem_q [DEPTH];
  logic             full;

  assign full    = (count_q == CNT_W'(DEPTH));
  assign ovf_o   = wr_i && full && !clr_i;
  assign count_o = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                count_q <= '0;
    else if (clr_i)             count_q <= '0;
    else if (wr_i && !full)     count_q <= count_q + 1'b1;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[i] <= '0;
      else if (!clr_i && wr_i && !full && count_q == CNT_W'(i)) mem_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rd_idx_i == CNT_W'(i)) rdata_o = mem_q[i];
  end

  a_r8_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> count_o == '0);
  a_r10_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/ent_cmd_out.sv
module ent_cmd_out #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         load_i,
  input  logic [W-1:0] ldata_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  output logic         empty_o
);
  logic         valid_q;
  logic [W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (flush_i) begin
      valid_q <= 1'b0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      data_q  <= ldata_i;
    end else if (valid_q && ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign empty_o = !valid_q;

  a_r11_hold_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && !ready_i && !flush_i |=> valid_q && $stable(data_q));
  a_r2_load_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !valid_q);
endmodule

// File: rtl/ent_cmd_ctrl.sv
module ent_cmd_ctrl
  import ent_cmd_pkg::*;
#(
  parameter int DEPTH = 13,
  parameter int REQ_W = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              boot_dis_i,
  input  logic              auto_mode_i,
  input  logic [REQ_W-1:0]  max_reqs_i,
  input  logic              ep_any_i,
  input  logic              sw_wvalid_i,
  input  logic [WORD_W-1:0] sw_wdata_i,
  output logic              sw_rdy_o,
  output logic              sw_done_o,
  input  logic              gen_ack_i,
  input  logic              out_empty_i,
  output logic              out_load_o,
  output logic [WORD_W-1:0] out_data_o,
  output logic              flush_o,
  input  logic [CNT_W-1:0]  rs_count_i,
  input  logic [CNT_W-1:0]  gn_count_i,
  input  logic [WORD_W-1:0] rs_word_i,
  input  logic [WORD_W-1:0] gn_word_i,
  output logic [CNT_W-1:0]  rd_idx_o,
  output logic              len_err_o
);
  seq_state_e       state_q, state_d;
  logic [REQ_W-1:0] req_cnt_q, req_cnt_d;
  logic [3:0]       left_q, left_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic             sel_rs_q, sel_rs_d;
  logic [CNT_W-1:0] cur_cnt;
  logic [CNT_W:0]   idx_inc;
  logic             ack_ok;

  assign cur_cnt  = sel_rs_q ? rs_count_i : gn_count_i;
  assign idx_inc  = {1'b0, idx_q} + 1'b1;
  assign ack_ok   = out_empty_i && gen_ack_i;
  assign rd_idx_o = idx_q;
  assign flush_o  = !enable_i;

  always_comb begin
    state_d    = state_q;
    req_cnt_d  = req_cnt_q;
    left_d     = left_q;
    idx_d      = idx_q;
    sel_rs_d   = sel_rs_q;
    out_load_o = 1'b0;
    out_data_o = '0;
    sw_rdy_o   = 1'b0;
    sw_done_o  = 1'b0;
    len_err_o  = 1'b0;
    if (!enable_i) begin
      state_d   = ST_IDLE;
      req_cnt_d = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: state_d = boot_dis_i ? ST_RUN : ST_BOOT_INS;
        ST_BOOT_INS: if (out_empty_i) begin
          out_load_o = 1'b1;
          out_data_o = mk_hdr(CMD_INST);
          state_d    = ST_BOOT_INS_ACK;
        end
        ST_BOOT_INS_ACK: if (ack_ok) state_d = ST_BOOT_GEN;
        ST_BOOT_GEN: if (out_empty_i) begin
          out_load_o = 1'b1;
          out_data_o = mk_hdr(CMD_GEN);
          state_d    = ST_BOOT_GEN_ACK;
        end
        ST_BOOT_GEN_ACK: if (ack_ok) state_d = ST_RUN;
        ST_RUN: begin
          if (auto_mode_i) begin
            idx_d = '0;
            if (req_cnt_q >= max_reqs_i) begin
              if (rs_count_i != '0) begin
                sel_rs_d = 1'b1;
                state_d  = ST_AUTO_SEND;
              end
            end else if (ep_any_i && gn_count_i != '0) begin
              sel_rs_d = 1'b0;
              state_d  = ST_AUTO_SEND;
            end
          end else begin
            sw_rdy_o = out_empty_i;
            if (sw_wvalid_i && out_empty_i) begin
              if (len_ok(sw_wdata_i)) begin
                out_load_o = 1'b1;
                out_data_o = sw_wdata_i;
                left_d     = hdr_len(sw_wdata_i);
                state_d    = (hdr_len(sw_wdata_i) == 4'd0) ? ST_SW_ACK : ST_SW_DATA;
              end else begin
                len_err_o = 1'b1;
              end
            end
          end
        end
        ST_SW_DATA: begin
          sw_rdy_o = out_empty_i;
          if (sw_wvalid_i && out_empty_i) begin
            out_load_o = 1'b1;
            out_data_o = sw_wdata_i;
            left_d     = left_q - 1'b1;
            if (left_q == 4'd1) state_d = ST_SW_ACK;
          end
        end
        ST_SW_ACK: if (ack_ok) begin
          sw_done_o = 1'b1;
          state_d   = ST_RUN;
        end
        ST_AUTO_SEND: if (out_empty_i) begin
          out_load_o = 1'b1;
          out_data_o = sel_rs_q ? rs_word_i : gn_word_i;
          idx_d      = idx_inc[CNT_W-1:0];
          if (idx_inc >= {1'b0, cur_cnt}) state_d = ST_AUTO_ACK;
        end
        ST_AUTO_ACK: if (ack_ok) begin
          if (sel_rs_q)               req_cnt_d = '0;
          else if (req_cnt_q != '1)   req_cnt_d = req_cnt_q + 1'b1;
          state_d = ST_RUN;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      req_cnt_q <= '0;
      left_q    <= '0;
      idx_q     <= '0;
      sel_rs_q  <= 1'b0;
    end else begin
      state_q   <= state_d;
      req_cnt_q <= req_cnt_d;
      left_q    <= left_d;
      idx_q     <= idx_d;
      sel_rs_q  <= sel_rs_d;
    end
  end

  a_r9_cnt_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> req_cnt_q == '0 && state_q == ST_IDLE);
  a_r2_wait_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && !gen_ack_i &&
    (state_q == ST_SW_ACK || state_q == ST_AUTO_ACK ||
     state_q == ST_BOOT_INS_ACK || state_q == ST_BOOT_GEN_ACK) |=> $stable(state_q));
endmodule

// File: rtl/ent_cmd_seq.sv
module ent_cmd_seq
  import ent_cmd_pkg::*;
#(
  parameter int DEPTH  = 13,
  parameter int REQ_W  = 16,
  parameter int NUM_EP = 4,
  parameter int ERR_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              boot_dis_i,
  input  logic              auto_mode_i,
  input  logic              fifo_clr_i,
  input  logic [REQ_W-1:0]  max_reqs_i,
  input  logic              sw_wvalid_i,
  input  logic [WORD_W-1:0] sw_wdata_i,
  output logic              sw_rdy_o,
  output logic              sw_done_o,
  input  logic              rs_wvalid_i,
  input  logic [WORD_W-1:0] rs_wdata_i,
  input  logic              gn_wvalid_i,
  input  logic [WORD_W-1:0] gn_wdata_i,
  input  logic [NUM_EP-1:0] ep_req_i,
  output logic              gen_valid_o,
  output logic [WORD_W-1:0] gen_data_o,
  input  logic              gen_ready_i,
  input  logic              gen_ack_i,
  input  logic              done_clr_i,
  input  logic [ERR_W-1:0]  err_test_i,
  output logic              intr_done_o,
  output logic              intr_fatal_o,
  output logic [ERR_W-1:0]  err_code_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              out_load, out_empty, flush, len_err, rs_ovf, gn_ovf;
  logic [WORD_W-1:0] out_data, rs_word, gn_word;
  logic [CNT_W-1:0]  rs_count, gn_count, rd_idx;
  logic [ERR_W-1:0]  err_q, err_set;
  logic              done_q;

  ent_cmd_store #(.DEPTH(DEPTH), .W(WORD_W)) u_rs_store (
    .clk_i, .rst_ni, .clr_i(fifo_clr_i), .wr_i(rs_wvalid_i), .wdata_i(rs_wdata_i),
    .rd_idx_i(rd_idx), .rdata_o(rs_word), .count_o(rs_count), .ovf_o(rs_ovf));

  ent_cmd_store #(.DEPTH(DEPTH), .W(WORD_W)) u_gn_store (
    .clk_i, .rst_ni, .clr_i(fifo_clr_i), .wr_i(gn_wvalid_i), .wdata_i(gn_wdata_i),
    .rd_idx_i(rd_idx), .rdata_o(gn_word), .count_o(gn_count), .ovf_o(gn_ovf));

  ent_cmd_ctrl #(.DEPTH(DEPTH), .REQ_W(REQ_W)) u_ctrl (
    .clk_i, .rst_ni, .enable_i, .boot_dis_i, .auto_mode_i, .max_reqs_i,
    .ep_any_i(|ep_req_i), .sw_wvalid_i, .sw_wdata_i, .sw_rdy_o, .sw_done_o,
    .gen_ack_i, .out_empty_i(out_empty), .out_load_o(out_load), .out_data_o(out_data),
    .flush_o(flush), .rs_count_i(rs_count), .gn_count_i(gn_count),
    .rs_word_i(rs_word), .gn_word_i(gn_word), .rd_idx_o(rd_idx), .len_err_o(len_err));

  ent_cmd_out #(.W(WORD_W)) u_out (
    .clk_i, .rst_ni, .flush_i(flush), .load_i(out_load), .ldata_i(out_data),
    .ready_i(gen_ready_i), .valid_o(gen_valid_o), .data_o(gen_data_o), .empty_o(out_empty));

  always_comb begin
    err_set    = err_test_i;
    err_set[0] = err_set[0] | len_err;
    if (ERR_W > 1) err_set[ERR_W-1] = err_set[ERR_W-1] | rs_ovf | gn_ovf;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= '0;
      done_q <= 1'b0;
    end else begin
      err_q <= err_q | err_set;
      if (sw_done_o)       done_q <= 1'b1;
      else if (done_clr_i) done_q <= 1'b0;
    end
  end

  assign err_code_o   = err_q;
  assign intr_fatal_o = |err_q;
  assign intr_done_o  = done_q;

  a_r10_fatal_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intr_fatal_o |=> intr_fatal_o);
  a_r5_len_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_err |=> err_code_o[0]);
  a_r9_idle_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !gen_valid_o);
  a_r4_done_sets_intr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_done_o |=> intr_done_o);
endmodule

// File: tb/ent_cmd_seq_test.sv
`timescale 1ns/1ps
module ent_cmd_seq_test;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        enable = 0, boot_dis = 0, auto_mode = 0, fifo_clr = 0;
  logic [15:0] max_reqs = 16'd2;
  logic        sw_wvalid = 0;
  logic [31:0] sw_wdata = '0;
  logic        sw_rdy, sw_done;
  logic        rs_wvalid = 0, gn_wvalid = 0;
  logic [31:0] rs_wdata = '0, gn_wdata = '0;
  logic [3:0]  ep_req = '0;
  logic        gen_valid, gen_ready = 1'b1, gen_ack = 1'b0;
  logic [31:0] gen_data;
  logic        done_clr = 0;
  logic [1:0]  err_test = '0;
  logic        intr_done, intr_fatal;
  logic [1:0]  err_code;

  int checks = 0, fails = 0, seen = 0, dones = 0;
  logic [31:0] expq[$];
  string cur_req = "R1";
  logic toggle_rdy = 0, stall_q = 0;
  logic [31:0] stall_data;

  always #2 clk = ~clk;

  ent_cmd_seq uut (
    .clk_i(clk), .rst_ni, .enable_i(enable), .boot_dis_i(boot_dis), .auto_mode_i(auto_mode),
    .fifo_clr_i(fifo_clr), .max_reqs_i(max_reqs), .sw_wvalid_i(sw_wvalid), .sw_wdata_i(sw_wdata),
    .sw_rdy_o(sw_rdy), .sw_done_o(sw_done), .rs_wvalid_i(rs_wvalid), .rs_wdata_i(rs_wdata),
    .gn_wvalid_i(gn_wvalid), .gn_wdata_i(gn_wdata), .ep_req_i(ep_req), .gen_valid_o(gen_valid),
    .gen_data_o(gen_data), .gen_ready_i(gen_ready), .gen_ack_i(gen_ack), .done_clr_i(done_clr),
    .err_test_i(err_test), .intr_done_o(intr_done), .intr_fatal_o(intr_fatal), .err_code_o(err_code));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    #1;
    if (toggle_rdy) gen_ready = ~gen_ready;
    if (stall_q) chk("R11", {gen_valid, gen_data}, {1'b1, stall_data});
    stall_q = gen_valid && !gen_ready && enable;
    stall_data = gen_data;
    if (sw_done) dones++;
    if (gen_valid && gen_ready) begin
      seen++;
      if (expq.size() == 0) chk(cur_req, gen_data, 32'hDEAD_DEAD);
      else chk(cur_req, gen_data, expq.pop_front());
    end
  end

  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask

  task automatic drain();
    int t = 0;
    while (expq.size() != 0 && t < 2000) begin @(negedge clk); #2; t++; end
    chk({cur_req, " drain"}, expq.size(), 0);
    expq.delete();
  endtask

  task automatic sw_put(input logic [31:0] w);
    int t = 0;
    @(negedge clk);
    while (!sw_rdy && t < 1000) begin @(negedge clk); t++; end
    sw_wvalid = 1; sw_wdata = w;
    @(negedge clk);
    sw_wvalid = 0;
  endtask

  task automatic push_rs(); expq.push_back(32'hC2);
    for (int i = 0; i < 12; i++) expq.push_back(32'hA000_0000 + i);
  endtask

  task automatic do_reset();
    rst_ni = 0; enable = 0; cyc(3); rst_ni = 1; cyc(1);
  endtask

  initial begin
    fork
      begin repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    join_none
    do_reset();
    chk("R9 reset valid", gen_valid, 0);
    chk("R10 reset err", {intr_fatal, err_code}, 0);
    chk("R4 reset done", intr_done, 0);

    // boot with delayed ack
    cur_req = "R1"; expq.push_back(32'h1); expq.push_back(32'h3);
    enable = 1; cyc(12);
    chk("R2 held before ack", seen, 1);
    gen_ack = 1; drain();
    chk("R1 boot words", seen, 2);

    enable = 0; cyc(2);
    chk("R9 disabled valid", gen_valid, 0);
    cur_req = "R3"; boot_dis = 1; enable = 1; cyc(12);
    chk("R3 no boot words", seen, 2);

    // software commands
    cur_req = "R4"; expq.push_back(32'h3);
    sw_put(32'h3); drain(); cyc(3);
    chk("R4 done pulse", dones, 1);
    chk("R4 done intr", intr_done, 1);
    done_clr = 1; cyc(1); done_clr = 0; cyc(1);
    chk("R4 done cleared", intr_done, 0);
    expq.push_back(32'hC2);
    for (int i = 0; i < 12; i++) expq.push_back(32'hB000_0000 + i);
    toggle_rdy = 1;
    sw_put(32'hC2);
    for (int i = 0; i < 12; i++) sw_put(32'hB000_0000 + i);
    drain(); toggle_rdy = 0; gen_ready = 1; cyc(3);
    chk("R4 reseed done", dones, 2);

    // automatic mode
    cur_req = "R6"; auto_mode = 1;
    rs_wvalid = 1; rs_wdata = 32'hC2; cyc(1);
    for (int i = 0; i < 12; i++) begin rs_wdata = 32'hA000_0000 + i; cyc(1); end
    rs_wvalid = 0; gn_wvalid = 1; gn_wdata = 32'h3; cyc(1); gn_wvalid = 0;
    cyc(10);
    chk("R6 gated without request", seen, 2 + 14);
    expq.push_back(32'h3); expq.push_back(32'h3); push_rs();
    expq.push_back(32'h3); expq.push_back(32'h3); push_rs();
    cur_req = "R7"; ep_req = 4'b0100; drain(); ep_req = 0; cyc(10);
    chk("R6 replay count", seen, 16 + 30);

    cur_req = "R9"; expq.push_back(32'h3); ep_req = 4'b0001; drain(); ep_req = 0; cyc(5);
    enable = 0; cyc(2); enable = 1;
    expq.push_back(32'h3); expq.push_back(32'h3); push_rs();
    ep_req = 4'b1000; drain(); ep_req = 0; cyc(10);
    chk("R9 count restarted", seen, 46 + 1 + 15);

    cur_req = "R8"; fifo_clr = 1; cyc(1); fifo_clr = 0;
    ep_req = 4'b1111; cyc(15); ep_req = 0;
    chk("R8 nothing after clear", seen, 62);

    // errors
    cur_req = "R5"; auto_mode = 0; sw_put(32'h52); cyc(6);
    chk("R5 discarded", seen, 62);
    chk("R5 err bit0", err_code, 2'b01);
    chk("R10 fatal", intr_fatal, 1);
    gn_wvalid = 1;
    for (int i = 0; i < 14; i++) begin gn_wdata = i; cyc(1); end
    gn_wvalid = 0; cyc(1);
    chk("R10 overflow bit", err_code, 2'b11);
    do_reset();
    chk("R10 reset clears", err_code, 2'b00);
    err_test = 2'b10; cyc(1); err_test = 0; cyc(3);
    chk("R10 forced bit", {intr_fatal, err_code}, 3'b110);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule